// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block puts one companded PCM word per frame onto a time-division highway as a serial bit stream. The word is taken in parallel when frame sync rises. It leaves most significant bit first. While the bits are on the line, the block raises an output enable for the data driver and pulls an active-low strobe low. An external line buffer can use that strobe as its gate. At all other times the enable is low, which stands for the data line being high-impedance.

There are two timing modes, chosen by a static select. In fixed mode the master clock is also the bit clock. The width of the sync pulse tells the two kinds of frame apart. A one-period pulse marks an ordinary frame. A two-period pulse marks a signaling frame, in which the last bit carries the signaling input instead of the word's LSB. In variable mode a separate data clock shifts the bits and sync works as a timeslot enable. While sync stays high, the word is sent again in every further slot. Signaling is never inserted in variable mode, and never when A-law is selected.

Master clock, data clock and sync are sampled by one internal clock, and edges are found on the sampled copies.

Top module: `pcm_tx_port`

## Requirements
- R1: While reset is asserted and directly after it, `dout_oe_o` is 0, `slot_strobe_n_o` is 1 and `dout_o` is 0.
- R2: In fixed mode (`var_mode_i`=0), the word goes out MSB first, one bit launched on each of the first eight master-clock rising edges after the sync rising edge. A master-clock edge sampled together with the sync rise is not counted. The enable drops on the ninth such edge.
- R3: The word and the signaling level are captured on the sampled sync rising edge. Later changes on `pcm_word_i` or `sig_i` do not alter the bits of that frame.
- R4: In fixed mode, sync still high on the first launch edge (a two-period pulse) marks a signaling frame, and its eighth bit equals the captured signaling level. A one-period pulse sends all eight word bits unchanged.
- R5: With `alaw_i`=1, a two-period pulse sends the word unchanged, with no signaling insertion.
- R6: In variable mode (`var_mode_i`=1), a bit is launched on each data-clock rising edge sampled while sync is high and was high on the previous sample. Master-clock edges have no effect, and no signaling insertion occurs.
- R7: In variable mode, after the eighth bit the same word starts again from its MSB while sync stays high. Sync low clears the enable on the next internal clock.
- R8: `slot_strobe_n_o` is always the inverse of `dout_oe_o`, and `dout_o` is 0 whenever `dout_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Master clock (bit clock in fixed mode), sampled |
| bclk_i | input | 1 | Separate data clock for variable mode, sampled |
| fsync_i | input | 1 | Frame sync / timeslot enable |
| var_mode_i | input | 1 | 0 = fixed timing, 1 = variable timing |
| alaw_i | input | 1 | 1 = A-law selected, signaling insertion off |
| sig_i | input | 1 | Signaling level for the last bit of signaling frames |
| pcm_word_i | input | WORD_W | Parallel companded word |
| dout_o | output | 1 | Serial data, valid while enabled |
| dout_oe_o | output | 1 | Driver enable; low means the line is high-impedance |
| slot_strobe_n_o | output | 1 | Active-low timeslot strobe for an external buffer |

## Verification
The sync rising edge and a master-clock rising edge land in the same sample at the start of every fixed frame, so the word capture and a possible bit launch coincide. The bench always raises both together and expects the first bit only on the next master-clock edge. The other collision is the signaling decision with the first launch edge: the bench drops sync either together with that edge or one edge later. It then compares the last bit against a signaling level that differs from the word's LSB, and it flips both the word and the signaling input after capture.

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_i,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              var_mode_i,
  input  logic              alaw_i,
  input  logic              sig_i,
  input  logic [WORD_W-1:0] pcm_word_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              slot_strobe_n_o
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic              mclk_q, bclk_q, fs_q;
  logic [WORD_W-1:0] word_q;
  logic              sig_q;
  logic              pend_q, act_q, sigf_q;
  logic [IDX_W-1:0]  idx_q;

  wire mclk_rise = mclk_i & ~mclk_q;
  wire bclk_rise = bclk_i & ~bclk_q;
  wire fs_rise   = fsync_i & ~fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      word_q <= '0;
      sig_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      sigf_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      mclk_q <= mclk_i;
      bclk_q <= bclk_i;
      fs_q   <= fsync_i;
      if (fs_rise) begin
        word_q <= pcm_word_i;
        sig_q  <= sig_i;
      end
      if (!var_mode_i) begin
        if (mclk_rise) begin
          if (pend_q) begin
            pend_q <= 1'b0;
            act_q  <= 1'b1;
            idx_q  <= '0;
            sigf_q <= fsync_i & ~alaw_i;
          end else if (act_q) begin
            if (idx_q == LAST) act_q <= 1'b0;
            else               idx_q <= idx_q + 1'b1;
          end
        end
        if (fs_rise) pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
        sigf_q <= 1'b0;
        if (!fsync_i) begin
          act_q <= 1'b0;
          idx_q <= '0;
        end else if (bclk_rise && fs_q) begin
          if (!act_q) begin
            act_q <= 1'b1;
            idx_q <= '0;
          end else begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
          end
        end
      end
    end
  end

  wire [IDX_W-1:0] pos     = LAST - idx_q;
  wire             cur_bit = (sigf_q && idx_q == LAST) ? sig_q : word_q[pos];

  assign dout_o          = act_q & cur_bit;
  assign dout_oe_o       = act_q;
  assign slot_strobe_n_o = ~act_q;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic mclk_i,
  input logic bclk_i,
  input logic fsync_i,
  input logic var_mode_i,
  input logic dout_oe_o,
  input logic slot_strobe_n_o
);
  p_launch_on_mclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!var_mode_i && $rose(dout_oe_o)) |-> ($past(mclk_i) && !$past(mclk_i, 2)));

  p_launch_on_bclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_i && $rose(dout_oe_o)) |-> ($past(bclk_i) && $past(fsync_i)));

  p_slot_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_i && !fsync_i) |=> !dout_oe_o);

  p_strobe_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe_o) |-> $fell(slot_strobe_n_o));

  p_strobe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe_o) |-> $rose(slot_strobe_n_o));
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mclk_i(mclk_i), .bclk_i(bclk_i),
  .fsync_i(fsync_i), .var_mode_i(var_mode_i),
  .dout_oe_o(dout_oe_o), .slot_strobe_n_o(slot_strobe_n_o)
);

// File: tb/pcm_tx_port_bench.sv
module pcm_tx_port_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       mclk = 1'b0, bclk = 1'b0, fsync = 1'b0;
  logic       var_mode = 1'b0, alaw = 1'b0, sig = 1'b0;
  logic [7:0] pcm_word = 8'h00;
  logic       dout_o, dout_oe_o, slot_strobe_n_o;

  pcm_tx_port #(.WORD_W(8)) u_pcm_tx_port (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .bclk_i(bclk), .fsync_i(fsync),
    .var_mode_i(var_mode), .alaw_i(alaw), .sig_i(sig), .pcm_word_i(pcm_word),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .slot_strobe_n_o(slot_strobe_n_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  logic mclk_seen = 1'b0, bclk_seen = 1'b0;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      bit launch;
      launch = var_mode ? (bclk && !bclk_seen) : (mclk && !mclk_seen);
      check(slot_strobe_n_o == !dout_oe_o, "R8", "strobe vs enable",
            int'(slot_strobe_n_o), int'(!dout_oe_o));
      if (!dout_oe_o)
        check(dout_o == 1'b0, "R8", "data while disabled", int'(dout_o), 0);
      if (launch && dout_oe_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected bit launch", 1, 0);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dout_o == e, t, "serial bit", int'(dout_o), int'(e));
        end
      end
    end
    mclk_seen = mclk;
    bclk_seen = bclk;
  end

  task automatic end_frame(string tag);
    check(exp_q.size() == 0, tag, "bits left unsent", exp_q.size(), 0);
    check(dout_oe_o == 1'b0, tag, "enable after frame", int'(dout_oe_o), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // Fixed mode: sync rises together with a master-clock edge (edge 0).
  task automatic fixed_frame(logic [7:0] w, bit s, bit dbl, string tag);
    bit ins = dbl && !alaw;
    for (int i = 7; i >= 0; i--) begin
      exp_q.push_back((i == 0 && ins) ? s : w[i]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    pcm_word = w; sig = s; fsync = 1'b1; mclk = 1'b1;
    tick(2); mclk = 1'b0; tick(2);
    mclk = 1'b1; pcm_word = ~w; sig = !s;
    if (!dbl) fsync = 1'b0;
    tick(2); mclk = 1'b0; tick(2);
    mclk = 1'b1; fsync = 1'b0;
    for (int e = 3; e <= 10; e++) begin
      tick(2); mclk = 1'b0; tick(2); mclk = 1'b1;
    end
    tick(2); mclk = 1'b0; tick(4);
    end_frame(tag);
  endtask

  // Variable mode: master clock toggles in opposite phase and must be ignored.
  task automatic var_frame(logic [7:0] w, int slots, string tag);
    for (int k = 0; k < slots; k++)
      for (int i = 7; i >= 0; i--) begin
        exp_q.push_back(w[i]);
        tag_q.push_back(tag);
      end
    @(negedge clk);
    pcm_word = w; sig = 1'b1; fsync = 1'b1; bclk = 1'b0; mclk = 1'b1;
    tick(2); pcm_word = ~w; sig = 1'b0; mclk = 1'b0;
    for (int b = 0; b < 8 * slots; b++) begin
      bclk = 1'b1; mclk = 1'b0; tick(2);
      bclk = 1'b0; mclk = 1'b1; tick(2);
    end
    fsync = 1'b0; mclk = 1'b0;
    tick(4);
    end_frame(tag);
  endtask

  initial begin
    tick(3);
    check(dout_oe_o == 1'b0, "R1", "enable in reset", int'(dout_oe_o), 0);
    check(slot_strobe_n_o == 1'b1, "R1", "strobe in reset", int'(slot_strobe_n_o), 1);
    check(dout_o == 1'b0, "R1", "data in reset", int'(dout_o), 0);
    rst_n = 1'b1;
    tick(3);
    check(dout_oe_o == 1'b0, "R1", "enable after reset", int'(dout_oe_o), 0);

    fixed_frame(8'hA5, 1'b0, 1'b0, "R2");
    fixed_frame(8'h3C, 1'b1, 1'b0, "R4");
    fixed_frame(8'h81, 1'b0, 1'b1, "R4");
    fixed_frame(8'h4E, 1'b1, 1'b1, "R4");
    fixed_frame(8'h00, 1'b1, 1'b1, "R3");
    alaw = 1'b1;
    fixed_frame(8'h5A, 1'b1, 1'b1, "R5");
    alaw = 1'b0;

    var_mode = 1'b1;
    tick(4);
    var_frame(8'hC3, 1, "R6");
    var_frame(8'h96, 3, "R7");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule